// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised set of on-chip peripheral sources (32 by default) and drives a single interrupt line toward the host processor, together with a configurable interrupt level. Software reaches four word registers over a simple single-cycle register bus. The registers are configuration, source mask, in-service and vector.

To take an interrupt, the host writes a one to bit 0 of the vector register. On that write the controller picks the best eligible source, latches its number into the vector register and marks the source in service. The host then reads the vector register to learn which source to handle. When servicing is done, the host writes a one to that source's bit in the in-service register.

A source requested but no longer eligible when the acknowledge arrives, for example because it was masked meanwhile, yields a reserved error vector. Such an acknowledge sets no in-service bit, so the acknowledge alone retires it.

Top module: `vic_top`

## Requirements
- R1: After reset the configuration, mask, in-service and vector registers read zero and `cpuIrq` is low.
- R2: A source whose mask bit (word address 1, bit n for source n) is zero never raises `cpuIrq` and is never returned as a vector.
- R3: `cpuIrq` is asserted only while the global enable (configuration bit 0, word address 0) is one and an eligible source exists.
- R4: Writing 1 to bit 0 of the vector register (word address 3) latches the winning source number into bits [5:0] of that register. Among otherwise equal sources the lowest number wins.
- R5: The source named by the promote field (configuration bits [12:8]) outranks every other source.
- R6: An acknowledge that returns a source sets that source's bit in the in-service register (word address 2). A source stays ineligible while its in-service bit is set.
- R7: Writing the in-service register clears exactly the bits written as one and leaves the others unchanged.
- R8: A request still asserted when its in-service bit clears becomes eligible again and raises `cpuIrq`.
- R9: While any source is in service, only sources of strictly higher priority than the best in-service source are eligible.
- R10: An acknowledge with no eligible source latches the error vector 32 (the source count) and leaves the in-service register unchanged.
- R11: The vector register changes only on an acknowledge write. A vector-register write with bit 0 clear, and any change in requests or mask, leave it as it was.
- R12: `cpuLevel` equals configuration bits [15:13], and the configuration register reads back the word last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 32 | Level-sensitive request, one bit per source |
| busAddr | input | 2 | Word address: 0 config, 1 mask, 2 in-service, 3 vector |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| cpuIrq | output | 1 | Interrupt line to the host |
| cpuLevel | output | 3 | Interrupt level presented with `cpuIrq` |

## Verification
The assertions assume that each bus write lasts one cycle and targets a single address. Under that assumption an acknowledge and an in-service clear never fall in the same cycle, which lets the in-service checks see exactly one update. They also assume that `srcReq` is a plain level whose changes take effect in the next eligibility decision. The stimulus changes requests and bus signals only on the falling edge and issues every register access through one write task, so acknowledges and clears stay in separate cycles. Each resolution is read back only after the edge that latched it.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DW = 32;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_ISR  = 2'd2;
  localparam logic [1:0] ADDR_VEC  = 2'd3;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_PRI_LSB = 8;
  localparam int CFG_LVL_LSB = 13;

  typedef struct packed {
    logic wrCfg;
    logic wrMask;
    logic wrIsr;
    logic ack;
  } strobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic          busWrEn,
  input  logic [1:0]    busAddr,
  input  logic          ackBit,
  output strobe_t       strb
);
  always_comb begin
    strb = '0;
    if (busWrEn) begin
      unique case (busAddr)
        ADDR_CFG:  strb.wrCfg  = 1'b1;
        ADDR_MASK: strb.wrMask = 1'b1;
        ADDR_ISR:  strb.wrIsr  = 1'b1;
        ADDR_VEC:  strb.ack    = ackBit;
        default:   strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int NSRC = 32,
  localparam int VW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int KW = VW + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] inSvc,
  input  logic [VW-1:0]   promo,
  output logic            winValid,
  output logic [VW-1:0]   winIdx
);
  localparam logic [KW-1:0] KEY_NONE = KW'(NSRC + 1);

  logic [KW-1:0] key [NSRC];
  logic [KW-1:0] svcFloor;
  logic [KW-1:0] best;

  for (genvar i = 0; i < NSRC; i++) begin : g_key
    assign key[i] = (promo == VW'(i)) ? '0 : KW'(i + 1);
  end

  always_comb begin
    svcFloor = KEY_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (inSvc[i] && key[i] < svcFloor) svcFloor = key[i];
    end
  end

  always_comb begin
    best     = KEY_NONE;
    winValid = 1'b0;
    winIdx   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && mask[i] && !inSvc[i] && key[i] < svcFloor && key[i] < best) begin
        best     = key[i];
        winValid = 1'b1;
        winIdx   = VW'(i);
      end
    end
  end

  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (req[winIdx] && mask[winIdx])); // R2
  AST_WIN_NOT_SVC: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> !inSvc[winIdx]); // R6
endmodule

// File: rtl/vic_dpath.sv
module vic_dpath
  import vic_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int LW   = 3,
  localparam int VW  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int VEW = VW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [DW-1:0]   wdata,
  input  logic [1:0]      rdAddr,
  input  logic [NSRC-1:0] srcReq,
  output logic [DW-1:0]   rdData,
  output logic            cpuIrq,
  output logic [LW-1:0]   cpuLevel
);
  localparam logic [VEW-1:0] ERRVEC = VEW'(NSRC);

  logic [DW-1:0]   cfgReg;
  logic [NSRC-1:0] maskReg;
  logic [NSRC-1:0] inSvc;
  logic [VEW-1:0]  vecReg;
  logic            winValid;
  logic [VW-1:0]   winIdx;

  vic_prio #(.NSRC(NSRC)) u_prio (
    .clk      (clk),
    .rstN     (rstN),
    .req      (srcReq),
    .mask     (maskReg),
    .inSvc    (inSvc),
    .promo    (cfgReg[CFG_PRI_LSB +: VW]),
    .winValid (winValid),
    .winIdx   (winIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= '0;
      maskReg <= '0;
      inSvc   <= '0;
      vecReg  <= '0;
    end else begin
      if (strb.wrCfg)  cfgReg  <= wdata;
      if (strb.wrMask) maskReg <= wdata[NSRC-1:0];
      if (strb.wrIsr)  inSvc   <= inSvc & ~wdata[NSRC-1:0];
      if (strb.ack) begin
        if (winValid) begin
          vecReg        <= VEW'(winIdx);
          inSvc[winIdx] <= 1'b1;
        end else begin
          vecReg <= ERRVEC;
        end
      end
    end
  end

  assign cpuIrq   = cfgReg[CFG_EN_BIT] & winValid;
  assign cpuLevel = cfgReg[CFG_LVL_LSB +: LW];

  always_comb begin
    unique case (rdAddr)
      ADDR_CFG:  rdData = cfgReg;
      ADDR_MASK: rdData = DW'(maskReg);
      ADDR_ISR:  rdData = DW'(inSvc);
      default:   rdData = DW'(vecReg);
    endcase
  end

  AST_ISR_W1C: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIsr |=> ((inSvc & $past(wdata[NSRC-1:0])) == '0)); // R7
  AST_ISR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIsr |=> ((inSvc | $past(wdata[NSRC-1:0])) == ($past(inSvc) | $past(wdata[NSRC-1:0])))); // R7
  AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && winValid) |=> inSvc[$past(winIdx)]); // R6
  AST_ERR_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && !winValid) |=> (vecReg == ERRVEC && $stable(inSvc))); // R10
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ack |=> $stable(vecReg)); // R11
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> ((srcReq & maskReg & ~inSvc) != '0)); // R2
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int LW   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcReq,
  input  logic [1:0]      busAddr,
  input  logic            busWrEn,
  input  logic [DW-1:0]   busWrData,
  output logic [DW-1:0]   busRdData,
  output logic            cpuIrq,
  output logic [LW-1:0]   cpuLevel
);
  strobe_t strb;

  vic_ctrl u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .ackBit  (busWrData[0]),
    .strb    (strb)
  );

  vic_dpath #(.NSRC(NSRC), .LW(LW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (busWrData),
    .rdAddr   (busAddr),
    .srcReq   (srcReq),
    .rdData   (busRdData),
    .cpuIrq   (cpuIrq),
    .cpuLevel (cpuLevel)
  );
endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcReq = '0;
  logic [1:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        cpuIrq;
  logic [2:0]  cpuLevel;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } item_t;
  item_t expQ[$];
  item_t actQ[$];

  always #4 clk = ~clk;

  vic_top dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .cpuIrq(cpuIrq), .cpuLevel(cpuLevel)
  );

  // monitor: pops and compares
  always @(negedge clk) begin
    while (expQ.size() > 0 && actQ.size() > 0) begin
      item_t e;
      item_t a;
      e = expQ.pop_front();
      a = actQ.pop_front();
      checks++;
      if (e.val !== a.val) begin
        bad++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", e.tag, a.val, e.val);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic chkRd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    expQ.push_back('{exp, tag});
    actQ.push_back('{busRdData, tag});
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    #1;
    expQ.push_back('{32'(exp), tag});
    actQ.push_back('{32'(cpuIrq), tag});
  endtask

  task automatic chkLvl(input logic [2:0] exp, input string tag);
    #1;
    expQ.push_back('{32'(exp), tag});
    actQ.push_back('{32'(cpuLevel), tag});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkRd(2'd0, 32'h0, "R1 cfg");
    chkRd(2'd1, 32'h0, "R1 mask");
    chkRd(2'd2, 32'h0, "R1 isr");
    chkRd(2'd3, 32'h0, "R1 vec");
    chkIrq(1'b0, "R1 irq");

    srcReq = 32'h20;
    wr(2'd1, 32'h20);
    chkIrq(1'b0, "R3 enable off");
    wr(2'd0, 32'hA001);
    chkIrq(1'b1, "R3 enable on");
    chkLvl(3'd5, "R12 level 5");

    srcReq = 32'h28;                 // source 3 requests but is masked
    wr(2'd3, 32'h1);
    chkRd(2'd3, 32'd5, "R2 R4 masked 3 skipped");
    chkRd(2'd2, 32'h20, "R6 isr set");
    chkIrq(1'b0, "R6 in service not offered");

    srcReq = 32'h08;
    wr(2'd1, 32'h28);
    chkRd(2'd3, 32'd5, "R11 vector held");
    chkIrq(1'b1, "R9 higher preempts");
    srcReq = 32'h28;

    wr(2'd2, 32'h20);
    chkRd(2'd2, 32'h0, "R7 clear");
    wr(2'd3, 32'h1);
    chkRd(2'd3, 32'd3, "R4 lowest wins");
    chkRd(2'd2, 32'h08, "R6 isr 3");
    chkIrq(1'b0, "R9 lower held off");

    srcReq = 32'h2A;
    wr(2'd1, 32'h2A);
    chkIrq(1'b1, "R9 preempt by 1");
    wr(2'd3, 32'h1);
    chkRd(2'd3, 32'd1, "R9 nested vector");
    chkRd(2'd2, 32'h0A, "R6 nested isr");
    wr(2'd2, 32'h02);
    chkRd(2'd2, 32'h08, "R7 only ones cleared");
    chkIrq(1'b1, "R8 level re-raise");
    wr(2'd2, 32'h08);
    chkRd(2'd2, 32'h0, "R7 clear rest");

    wr(2'd0, 32'hA501);
    chkRd(2'd0, 32'hA501, "R12 cfg readback");
    wr(2'd3, 32'h1);
    chkRd(2'd3, 32'd5, "R5 promoted wins");
    chkIrq(1'b0, "R5 R9 promoted holds off");
    wr(2'd2, 32'h20);
    chkIrq(1'b1, "R8 pending again");

    wr(2'd1, 32'h0);
    chkIrq(1'b0, "R2 all masked");
    wr(2'd3, 32'h1);
    chkRd(2'd3, 32'd32, "R10 error vector");
    chkRd(2'd2, 32'h0, "R10 isr unchanged");
    wr(2'd3, 32'h0);
    chkRd(2'd3, 32'd32, "R11 write without ack bit");

    wr(2'd1, 32'h2A);
    chkIrq(1'b1, "R3 before disable");
    wr(2'd0, 32'hA500);
    chkIrq(1'b0, "R3 disabled");
    wr(2'd0, 32'hE001);
    chkLvl(3'd7, "R12 level 7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule